// File: doc/BRIEF.md
# Event Timer Unit

The unit holds three event timers that share one free-running main counter. Each timer has its own compare value and enable. When the counter advances onto a timer's compare value, that timer latches a sticky interrupt status. The counter advances once for every rising edge of a slow reference clock. That clock arrives asynchronously and is brought into the fast system clock domain, so the increments are unevenly spaced but their average rate matches the reference.

A flat register port writes and reads the global controls, the counter, the status and the per-timer settings. An interrupt router sends each timer's level to the system interrupt lines. In standard mode each timer picks one of four high lines (IRQ20 to IRQ23) through its route field. In legacy-replacement mode timer 0 and timer 1 take over the legacy interval-timer and clock lines, and the external sources that normally drive those lines are blocked.

Register map (word addresses): 0 is global control, with bit 0 = run and bit 1 = legacy replacement. 1 is interrupt status, with bit i = timer i, write 1 to clear. 2 is the main counter. 4+2i is timer i control, with bit 0 = enable and bits 2:1 = route select. 5+2i is timer i compare value.

Top module: `evt_timer_unit`

## Requirements
- R1: All three timers compare against the one main counter. Timers given the same compare value latch status on the same advance.
- R2: Each rising edge of `ref_clk_in` produces exactly one single-cycle increment. The counter shows the new value after the third rising `clk` edge following the reference edge, and not after the second.
- R3: While run (address 0 bit 0) is 1, the counter increases by exactly 1 per increment and wraps modulo 2^CNT_W. While run is 0 it holds its value. Two reads separated by an increment differ.
- R4: A write to the counter (address 2) takes effect only while run is 0. While run is 1 the write is ignored.
- R5: When the counter advances onto a timer's compare value and the timer is enabled, the timer's status bit is set. A disabled timer's status bit stays clear.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A clear issued while the counter still sits on the compare value is not undone, because status is set only when the counter arrives on the value.
- R7: A timer's interrupt level is high exactly while its status is set and its enable is 1.
- R8: With legacy replacement (address 0 bit 1) at 0, route value k (0 to 3) places the timer's level on `irq_hi[k]` (IRQ20+k). `pit_irq_in` drives `irq0_pic` and `irq2_apic`, and `rtc_irq_in` drives `irq8_line`.
- R9: With legacy replacement at 1, the timer 0 level drives `irq0_pic` and `irq2_apic`, and the timer 1 level drives `irq8_line`. `pit_irq_in` and `rtc_irq_in` are blocked. Timers 0 and 1 drive no `irq_hi` line, and timer 2 still follows its route field.
- R10: The global control, timer control and compare registers read back the values written to them, with the field positions given in the register map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ref_clk_in | input | 1 | Asynchronous slow reference clock |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data, combinational from `reg_addr` |
| pit_irq_in | input | 1 | Legacy interval-timer interrupt source |
| rtc_irq_in | input | 1 | Real-time-clock interrupt source |
| irq0_pic | output | 1 | Line 0 on the legacy controller path |
| irq2_apic | output | 1 | Line 2 on the advanced controller path |
| irq8_line | output | 1 | Line 8 on both paths |
| irq_hi | output | 4 | Lines IRQ20 to IRQ23, bit k = IRQ20+k |

## Verification
The bench builds the unit with CNT_W = 8, so the counter wrap from 0xFF to 0x00 is only a couple of reference edges away. Three timers and four route values keep the routing space small. With all three statuses set, the bench sweeps every combination of the three route fields, the eight enable masks, both routing modes and all four states of the two legacy sources, and computes each expected line pattern arithmetically.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
  localparam int NTMR  = 3;
  localparam int NLINE = 4;
  localparam int AW    = 4;

  localparam logic [AW-1:0] A_GCFG = 4'd0;
  localparam logic [AW-1:0] A_STAT = 4'd1;
  localparam logic [AW-1:0] A_CNT  = 4'd2;

  function automatic logic [AW-1:0] tcfg_addr(input int i);
    return AW'(4 + 2 * i);
  endfunction

  function automatic logic [AW-1:0] tcmp_addr(input int i);
    return AW'(5 + 2 * i);
  endfunction

  function automatic logic [NLINE-1:0] route_onehot(input logic [1:0] sel);
    return NLINE'(1) << sel;
  endfunction
endpackage

// File: rtl/evt_tick_sync.sv
module evt_tick_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic run,
  output logic tick
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], ref_in};
  end

  // sh[0], sh[1]: two-flop synchronizer; sh[2]: edge history
  assign tick = run && sh[1] && !sh[2];
endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt
);
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (wr)   cnt <= wdata;
    else if (tick) cnt <= step(cnt);
  end
endmodule

// File: rtl/evt_timer_slot.sv
module evt_timer_slot #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             arrive,
  input  logic             cfg_we,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             clr,
  output logic             en,
  output logic [1:0]       route,
  output logic [CNT_W-1:0] cmp,
  output logic             stat,
  output logic             hit,
  output logic             lvl
);
  assign hit = arrive && en && (cmp == cnt);
  assign lvl = stat && en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      route <= '0;
      cmp   <= '0;
      stat  <= 1'b0;
    end else begin
      if (cfg_we) {route, en} <= wdata[2:0];
      if (cmp_we) cmp <= wdata;
      if (hit)      stat <= 1'b1;
      else if (clr) stat <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router
  import evt_tmr_pkg::*;
(
  input  logic                  legacy,
  input  logic [NTMR-1:0]       lvl,
  input  logic [NTMR-1:0][1:0]  route,
  input  logic                  pit_in,
  input  logic                  rtc_in,
  output logic                  irq0,
  output logic                  irq2,
  output logic                  irq8,
  output logic [NLINE-1:0]      irq_hi
);
  always_comb begin
    irq_hi = '0;
    for (int i = 0; i < NTMR; i++) begin
      if (lvl[i] && !(legacy && i < 2)) irq_hi = irq_hi | route_onehot(route[i]);
    end
    irq0 = legacy ? lvl[0] : pit_in;
    irq2 = legacy ? lvl[0] : pit_in;
    irq8 = legacy ? lvl[1] : rtc_in;
  end
endmodule

// File: rtl/evt_timer_unit.sv
module evt_timer_unit
  import evt_tmr_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk_in,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             pit_irq_in,
  input  logic             rtc_irq_in,
  output logic             irq0_pic,
  output logic             irq2_apic,
  output logic             irq8_line,
  output logic [3:0]       irq_hi
);
  logic                      run_q, leg_q, inc_d;
  logic                      tick_w, cnt_wr;
  logic [CNT_W-1:0]          cnt_q;
  logic [NTMR-1:0]           en_v, stat_v, hit_v, lvl_v;
  logic [NTMR-1:0][1:0]      route_a;
  logic [NTMR-1:0][CNT_W-1:0] cmp_a;

  assign cnt_wr = reg_we && (reg_addr == A_CNT) && !run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      leg_q <= 1'b0;
      inc_d <= 1'b0;
    end else begin
      inc_d <= tick_w;
      if (reg_we && reg_addr == A_GCFG) {leg_q, run_q} <= reg_wdata[1:0];
    end
  end

  evt_tick_sync u_sync (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_clk_in), .run(run_q), .tick(tick_w)
  );

  evt_main_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .wr(cnt_wr), .wdata(reg_wdata), .cnt(cnt_q)
  );

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    evt_timer_slot #(.CNT_W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .arrive(inc_d),
      .cfg_we(reg_we && reg_addr == tcfg_addr(i)),
      .cmp_we(reg_we && reg_addr == tcmp_addr(i)),
      .wdata(reg_wdata),
      .clr(reg_we && reg_addr == A_STAT && reg_wdata[i]),
      .en(en_v[i]), .route(route_a[i]), .cmp(cmp_a[i]),
      .stat(stat_v[i]), .hit(hit_v[i]), .lvl(lvl_v[i])
    );
  end

  evt_irq_router u_route (
    .legacy(leg_q), .lvl(lvl_v), .route(route_a),
    .pit_in(pit_irq_in), .rtc_in(rtc_irq_in),
    .irq0(irq0_pic), .irq2(irq2_apic), .irq8(irq8_line), .irq_hi(irq_hi)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_GCFG:  reg_rdata[1:0] = {leg_q, run_q};
      A_STAT:  reg_rdata[NTMR-1:0] = stat_v;
      A_CNT:   reg_rdata = cnt_q;
      default: begin
        for (int i = 0; i < NTMR; i++) begin
          if (reg_addr == tcfg_addr(i)) reg_rdata[2:0] = {route_a[i], en_v[i]};
          if (reg_addr == tcmp_addr(i)) reg_rdata = cmp_a[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CNT_W = 64,
  parameter int NTMR  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             run,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt,
  input logic [NTMR-1:0]  stat,
  input logic [NTMR-1:0]  en,
  input logic [NTMR-1:0]  lvl,
  input logic             legacy,
  input logic             irq8,
  input logic [3:0]       irq_hi
);
  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt));

  for (genvar i = 0; i < NTMR; i++) begin : g_dis
    // R5
    dis_no_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[i] && !stat[i]) |=> !stat[i]);
  end

  // R9
  rtc_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy && !lvl[1]) |-> !irq8);

  // R8
  hi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hi != 4'b0) |-> (lvl != '0));
endmodule

bind evt_timer_unit evt_timer_chk #(.CNT_W(CNT_W), .NTMR(evt_tmr_pkg::NTMR)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .run(run_q), .cnt_wr(cnt_wr),
  .cnt(cnt_q), .stat(stat_v), .en(en_v), .lvl(lvl_v), .legacy(leg_q),
  .irq8(irq8_line), .irq_hi(irq_hi)
);

// File: tb/sim_evt_timer_unit.sv
module sim_evt_timer_unit;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ref_clk_in = 1'b0;
  logic         reg_we = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         pit_irq_in = 1'b0, rtc_irq_in = 1'b0;
  logic         irq0_pic, irq2_apic, irq8_line;
  logic [3:0]   irq_hi;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evt_timer_unit #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pit_irq_in(pit_irq_in), .rtc_irq_in(rtc_irq_in), .irq0_pic(irq0_pic),
    .irq2_apic(irq2_apic), .irq8_line(irq8_line), .irq_hi(irq_hi)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ref_edge();
    @(negedge clk); ref_clk_in = 1'b1;
    repeat (3) @(negedge clk);
    ref_clk_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    rd(4'd2, v); check("R3 reset counter", v, 0);
    rd(4'd0, v); check("R10 reset gcfg", v, 0);
    #1 check("R8 reset lines", {irq0_pic, irq2_apic, irq8_line, irq_hi}, 0);

    // R4 / R10: counter write while stopped, ignored while running
    wr(4'd2, 8'hFE); rd(4'd2, v); check("R4 write stopped", v, 8'hFE);
    wr(4'd0, 8'h01); rd(4'd0, v); check("R10 gcfg readback", v, 8'h01);
    wr(4'd2, 8'h10); rd(4'd2, v); check("R4 write ignored running", v, 8'hFE);

    // R2 timing: reference edge at negedge N0, new value visible at N3
    @(negedge clk); ref_clk_in = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R2 not after two edges", reg_rdata, 8'hFE);
    @(negedge clk);
    check("R2 after three edges", reg_rdata, 8'hFF);
    ref_clk_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 one increment per edge", reg_rdata, 8'hFF);

    // R3 wrap and consecutive reads
    ref_edge(); rd(4'd2, v); check("R3 wrap", v, 8'h00);
    ref_edge(); rd(4'd2, v2); check("R3 reads differ", v2 != v, 1);
    check("R3 plus one", v2, 8'h01);
    wr(4'd0, 8'h00); ref_edge(); rd(4'd2, v); check("R3 hold when stopped", v, 8'h01);

    // R5: enabled timers latch, disabled does not
    wr(4'd2, 8'h20);
    wr(4'd4, 8'h01); wr(4'd6, 8'h00); wr(4'd8, 8'h01);
    wr(4'd5, 8'h21); wr(4'd7, 8'h21); wr(4'd9, 8'h21);
    rd(4'd4, v); check("R10 tcfg readback", v, 8'h01);
    rd(4'd9, v); check("R10 cmp readback", v, 8'h21);
    wr(4'd0, 8'h01); ref_edge();
    rd(4'd1, v); check("R5 status enabled only", v, 8'h05);
    #1 check("R7 level on route 0", irq_hi, 4'b0001);
    // R6: clear while counter sits on value stays cleared
    wr(4'd1, 8'h01); repeat (4) @(negedge clk);
    rd(4'd1, v); check("R6 w1c holds", v, 8'h04);
    wr(4'd1, 8'h00); rd(4'd1, v); check("R6 write zero no effect", v, 8'h04);

    // R1: all timers set on one shared counter advance
    wr(4'd1, 8'h07); wr(4'd0, 8'h00); wr(4'd2, 8'h30);
    for (int i = 0; i < 3; i++) begin
      wr(4'(4 + 2 * i), 8'h01); wr(4'(5 + 2 * i), 8'h31);
    end
    wr(4'd0, 8'h01); ref_edge();
    rd(4'd1, v); check("R1 shared counter", v, 8'h07);

    // R7/R8/R9 sweep
    for (int lg = 0; lg < 2; lg++) begin
      wr(4'd0, W'(lg * 2));
      for (int rc = 0; rc < 64; rc++) begin
        for (int em = 0; em < 8; em++) begin
          for (int i = 0; i < 3; i++)
            wr(4'(4 + 2 * i), W'((((rc >> (2 * i)) & 3) << 1) | ((em >> i) & 1)));
          for (int ps = 0; ps < 4; ps++) begin
            logic [3:0] eh;
            logic e0, e8;
            @(negedge clk);
            pit_irq_in = ps[0]; rtc_irq_in = ps[1];
            eh = '0;
            for (int i = 0; i < 3; i++)
              if (((em >> i) & 1) == 1 && !(lg == 1 && i < 2))
                eh = eh | (4'b1 << ((rc >> (2 * i)) & 3));
            e0 = (lg == 1) ? em[0] : ps[0];
            e8 = (lg == 1) ? em[1] : ps[1];
            #1 check(lg ? "R9 legacy routing" : "R8 standard routing",
                     {irq0_pic, irq2_apic, irq8_line, irq_hi}, {e0, e0, e8, eh});
          end
        end
      end
    end

    // R6 final clear, R7 lines drop
    pit_irq_in = 1'b0; rtc_irq_in = 1'b0;
    wr(4'd0, 8'h00);
    for (int i = 0; i < 3; i++) wr(4'(4 + 2 * i), 8'h01);
    wr(4'd1, 8'h07); rd(4'd1, v); check("R6 clear all", v, 0);
    #1 check("R7 lines low after clear", irq_hi, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule